// File: doc/BRIEF.md
# Tag-Compare Cache Line Array

This block is the storage of a direct-mapped cache. Each line holds a valid flag, a dirty flag, a short tag and a group of data words. A cache controller drives a single request port. The `comp` input picks one of two modes. In compare mode, the stored tag is checked against the request tag, and a write is allowed only when the tags match. In raw mode, the array acts like a plain RAM, so the controller can install a line after a miss and read out a victim line for writeback.

All results are combinational in the cycle of the request. State changes take effect on the rising clock edge, so a request in the next cycle sees them. Reset clears the valid and dirty flags of every line. Tags and data keep whatever they held before.

Top module: `tagcmp_line_array`

## Requirements
- R1: The array holds 256 lines of four 16-bit words with a 5-bit tag. `index` selects the line and `offset[2:1]` selects the word, so every line, including index 0 and 255, stores and returns all four words independently.
- R2: With `enable` low, every output (hit, dirty, valid, err, tag_out, data_out) is 0, and `write` and `comp` change no state.
- R3: With `enable` high and `offset[0]` = 1, `err` is 1 and no write happens in that cycle. With `offset[0]` = 0, `err` is 0.
- R4: With `comp` = 1, `hit` is 1 in the same cycle exactly when the stored tag at `index` equals `tag_in`, whatever the line's valid flag. With `comp` = 0, `hit` is 0.
- R5: A compare write (`comp` = 1, `write` = 1) whose tag matches stores `data_in` into the selected word and sets the line's dirty flag. While the tag matches in such a cycle, the `dirty` output is 0.
- R6: A compare write whose tag does not match changes no state. In that cycle, `dirty` and `valid` show the line's stored flags.
- R7: A raw write (`comp` = 0, `write` = 1) stores `data_in` in the selected word, `tag_in` as the tag and `valid_in` as the valid flag, and clears the dirty flag. The `dirty` output is 0 in that cycle.
- R8: With `write` = 0, `tag_out` shows the stored tag, `data_out` shows the selected word, and `valid` and `dirty` show the line's flags. Whenever `write` = 1, `tag_out` and `data_out` are 0.
- R9: Reset clears the valid and dirty flags of every line. Tags and data are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Request qualifier |
| index | input | 8 | Line select |
| offset | input | 3 | Byte offset; bits 2:1 pick the word, bit 0 must be 0 |
| comp | input | 1 | 1 = tag-checked mode, 0 = raw mode |
| write | input | 1 | 1 = write request |
| tag_in | input | 5 | Request tag (compared, or stored on a raw write) |
| data_in | input | 16 | Write data |
| valid_in | input | 1 | Valid flag stored on a raw write |
| hit | output | 1 | Tag match in compare mode |
| dirty | output | 1 | Dirty flag of the selected line |
| tag_out | output | 5 | Stored tag on reads |
| data_out | output | 16 | Selected word on reads |
| valid | output | 1 | Valid flag of the selected line |
| err | output | 1 | Misaligned offset |

## Verification
The properties assume that tag and data reads only touch lines whose tag has been written since power-up. They also assume that inputs settle well away from the clock edge, and that a follow-up read reuses the index and offset of the write it checks. The stimulus fills a line with a raw write before any compare access to it. It keeps every random access on a few lines that were installed first. It marks tags and words that were never written as unknown, so their values are not compared. Requests change on the falling edge and are sampled a quarter period later.

// File: rtl/tagcmp_line_array.sv
module tagcmp_line_array #(
  parameter int LINES  = 256,
  parameter int TAG_W  = 5,
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int SEL_W = $clog2(WORDS),
  localparam int OFF_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [IDX_W-1:0]  index,
  input  logic [OFF_W-1:0]  offset,
  input  logic              comp,
  input  logic              write,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [WORD_W-1:0] data_in,
  input  logic              valid_in,
  output logic              hit,
  output logic              dirty,
  output logic [TAG_W-1:0]  tag_out,
  output logic [WORD_W-1:0] data_out,
  output logic              valid,
  output logic              err
);
  localparam int ADDR_W = IDX_W + SEL_W;

  logic [WORD_W-1:0] words_q [LINES*WORDS];
  logic [TAG_W-1:0]  tags_q  [LINES];
  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  drt_q;

  logic [ADDR_W-1:0] waddr;
  logic              misalign, tag_eq, raw_wr, cmp_wr, rd;

  assign waddr    = {index, offset[OFF_W-1:1]};
  assign misalign = offset[0];
  assign tag_eq   = tags_q[index] == tag_in;
  assign raw_wr   = enable & write & ~comp & ~misalign;
  assign cmp_wr   = enable & write & comp & tag_eq & ~misalign;
  assign rd       = enable & ~write;

  assign hit      = enable & comp & tag_eq;
  assign err      = enable & misalign;
  assign valid    = enable & vld_q[index];
  assign dirty    = enable & drt_q[index] & ~(write & (~comp | tag_eq));
  assign tag_out  = rd ? tags_q[index] : '0;
  assign data_out = rd ? words_q[waddr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (raw_wr) begin
      vld_q[index] <= valid_in;
      drt_q[index] <= 1'b0;
    end else if (cmp_wr) begin
      drt_q[index] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && (raw_wr || cmp_wr)) words_q[waddr] <= data_in;
    if (!rst && raw_wr) tags_q[index] <= tag_in;
  end
endmodule

module tagcmp_line_array_chk #(
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 3,
  parameter int TAG_W  = 5,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [IDX_W-1:0]  index,
  input logic [OFF_W-1:0]  offset,
  input logic              comp,
  input logic              write,
  input logic [TAG_W-1:0]  tag_in,
  input logic [WORD_W-1:0] data_in,
  input logic              valid_in,
  input logic              hit,
  input logic              dirty,
  input logic [TAG_W-1:0]  tag_out,
  input logic [WORD_W-1:0] data_out,
  input logic              valid,
  input logic              err
);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!hit && !dirty && !valid && !err && tag_out == '0 && data_out == '0));

  // R3
  err_align_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (enable && offset[0]));

  // R4
  hit_mode_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (enable && comp));

  // R5
  cwhit_dirty_low_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && comp && write && hit) |-> !dirty);

  // R8
  write_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && write) |-> (tag_out == '0 && data_out == '0));

  // R7
  raw_readback_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && enable && write && !comp && !offset[0]) && enable && !write && !comp
     && index == $past(index) && offset == $past(offset))
    |-> (data_out == $past(data_in) && tag_out == $past(tag_in)
         && valid == $past(valid_in) && !dirty));

  // R5
  cwhit_readback_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && enable && write && comp && hit && !offset[0]) && enable && !write
     && index == $past(index) && offset == $past(offset))
    |-> (data_out == $past(data_in) && dirty));
endmodule

bind tagcmp_line_array tagcmp_line_array_chk #(
  .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/tb_tagcmp_line_array.sv
`timescale 1ns/1ps
module tb_tagcmp_line_array;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, comp = 1'b0, write = 1'b0, valid_in = 1'b0;
  logic [7:0]  index = '0;
  logic [2:0]  offset = '0;
  logic [4:0]  tag_in = '0;
  logic [15:0] data_in = '0;
  logic        hit, dirty, valid, err;
  logic [4:0]  tag_out;
  logic [15:0] data_out;

  always #10 clk = ~clk;

  tagcmp_line_array dut (.*);

  typedef struct {
    logic hit, dirty, valid, err;
    logic [4:0] tag;
    logic [15:0] data;
    bit c_hit, c_dirty, c_tag, c_data;
  } exp_t;

  exp_t  sb_q[$];
  string rq_q[$];
  event  go;
  int    checks = 0, errors = 0;
  bit    finished = 0;

  bit          mv[256], md[256], tk[256];
  logic [4:0]  mt[256];
  logic [15:0] mw[1024];
  bit          wk[1024];

  task automatic report(string rq, string f, logic [15:0] a, logic [15:0] e);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h at %0t", rq, f, a, e, $time);
  endtask

  initial begin
    forever begin
      @(go);
      #5;
      while (sb_q.size() > 0) begin
        exp_t e;
        string r;
        e = sb_q.pop_front();
        r = rq_q.pop_front();
        checks++;
        if (err !== e.err) report(r, "err", 16'(err), 16'(e.err));
        if (valid !== e.valid) report(r, "valid", 16'(valid), 16'(e.valid));
        if (e.c_hit && hit !== e.hit) report(r, "hit", 16'(hit), 16'(e.hit));
        if (e.c_dirty && dirty !== e.dirty) report(r, "dirty", 16'(dirty), 16'(e.dirty));
        if (e.c_tag && tag_out !== e.tag) report(r, "tag_out", 16'(tag_out), 16'(e.tag));
        if (e.c_data && data_out !== e.data) report(r, "data_out", data_out, e.data);
      end
    end
  end

  task automatic op(bit en, bit cmp, bit wr, logic [7:0] idx, logic [2:0] off,
                    logic [4:0] tg, logic [15:0] dat, bit vin, string rq);
    exp_t e;
    int w;
    bit tm;
    @(negedge clk);
    enable = en; comp = cmp; write = wr; index = idx; offset = off;
    tag_in = tg; data_in = dat; valid_in = vin;
    w = {idx, off[2:1]};
    tm = tk[idx] && (mt[idx] == tg);
    if (!en) begin
      e = '{hit:0, dirty:0, valid:0, err:0, tag:'0, data:'0,
            c_hit:1, c_dirty:1, c_tag:1, c_data:1};
    end else begin
      e.err = off[0];
      e.valid = mv[idx];
      e.hit = cmp && tm;
      e.c_hit = !cmp || tk[idx];
      e.dirty = md[idx] && !(wr && (!cmp || tm));
      e.c_dirty = !(md[idx] && wr && cmp && !tk[idx]);
      e.tag = wr ? 5'd0 : mt[idx];
      e.c_tag = wr || tk[idx];
      e.data = wr ? 16'd0 : mw[w];
      e.c_data = wr || wk[w];
    end
    sb_q.push_back(e);
    rq_q.push_back(rq);
    ->go;
    if (en && wr && !off[0]) begin
      if (!cmp) begin
        mt[idx] = tg; tk[idx] = 1; mv[idx] = vin; md[idx] = 0;
        mw[w] = dat; wk[w] = 1;
      end else if (tm) begin
        mw[w] = dat; md[idx] = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; enable = 0; write = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    foreach (mv[i]) begin mv[i] = 0; md[i] = 0; end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lines [4] = '{8'd0, 8'd5, 8'd200, 8'd255};
    logic [4:0] tags  [4] = '{5'h13, 5'h1f, 5'h00, 5'h07};
    repeat (2) @(negedge clk);
    do_reset();
    // R9 reset state
    op(1, 0, 0, 8'd0,   3'd0, 5'd0, 16'd0, 0, "R9");
    op(1, 0, 0, 8'd128, 3'd2, 5'd0, 16'd0, 0, "R9");
    op(1, 0, 0, 8'd255, 3'd6, 5'd0, 16'd0, 0, "R9");
    // R7 / R8 raw write then read
    op(1, 0, 1, 8'd5, 3'd4, 5'h13, 16'hBEEF, 1, "R7");
    op(1, 0, 0, 8'd5, 3'd4, 5'h00, 16'h0000, 0, "R8");
    // R4 compare reads
    op(1, 1, 0, 8'd5, 3'd4, 5'h13, 16'h0, 0, "R4");
    op(1, 1, 0, 8'd5, 3'd4, 5'h12, 16'h0, 0, "R4");
    // R5 compare write hit
    op(1, 1, 1, 8'd5, 3'd2, 5'h13, 16'h1234, 0, "R5");
    op(1, 0, 0, 8'd5, 3'd2, 5'h00, 16'h0, 0, "R5");
    // R6 compare write miss
    op(1, 1, 1, 8'd5, 3'd4, 5'h01, 16'hAAAA, 0, "R6");
    op(1, 0, 0, 8'd5, 3'd4, 5'h00, 16'h0, 0, "R6");
    // R2 disabled write
    op(0, 0, 1, 8'd5, 3'd4, 5'h09, 16'h5555, 0, "R2");
    op(0, 1, 1, 8'd5, 3'd2, 5'h13, 16'h6666, 0, "R2");
    op(1, 0, 0, 8'd5, 3'd4, 5'h00, 16'h0, 0, "R2");
    op(1, 0, 0, 8'd5, 3'd2, 5'h00, 16'h0, 0, "R2");
    // R3 misaligned
    op(1, 0, 1, 8'd5, 3'd5, 5'h02, 16'h7777, 0, "R3");
    op(1, 1, 1, 8'd5, 3'd3, 5'h13, 16'h8888, 0, "R3");
    op(1, 0, 0, 8'd5, 3'd4, 5'h00, 16'h0, 0, "R3");
    op(1, 0, 0, 8'd5, 3'd2, 5'h00, 16'h0, 0, "R3");
    op(1, 0, 0, 8'd5, 3'd1, 5'h00, 16'h0, 0, "R3");
    // R7 raw write clears dirty
    op(1, 0, 1, 8'd5, 3'd0, 5'h13, 16'h0F0F, 1, "R7");
    op(1, 0, 0, 8'd5, 3'd2, 5'h00, 16'h0, 0, "R7");
    // R1 boundary lines, all words
    for (int k = 0; k < 4; k++) begin
      op(1, 0, 1, 8'd0,   3'(2*k), 5'h1f, 16'(16'hA000 + k), 1, "R1");
      op(1, 0, 1, 8'd255, 3'(2*k), 5'h07, 16'(16'hC000 + k), 1, "R1");
    end
    for (int k = 0; k < 4; k++) begin
      op(1, 0, 0, 8'd0,   3'(2*k), 5'h0, 16'h0, 0, "R1");
      op(1, 0, 0, 8'd255, 3'(2*k), 5'h0, 16'h0, 0, "R1");
    end
    // R4 hit independent of valid
    op(1, 0, 1, 8'd200, 3'd0, 5'h00, 16'h0042, 0, "R7");
    op(1, 1, 0, 8'd200, 3'd0, 5'h00, 16'h0, 0, "R4");
    op(1, 0, 0, 8'd200, 3'd0, 5'h00, 16'h0, 0, "R8");
    // random traffic on installed lines
    for (int n = 0; n < 600; n++) begin
      bit en, cm, wr, vi;
      logic [7:0] li;
      logic [2:0] of;
      logic [4:0] tg;
      string r;
      en = ($urandom_range(9) != 0);
      cm = $urandom_range(1);
      wr = $urandom_range(1);
      vi = ($urandom_range(3) != 0);
      li = lines[$urandom_range(3)];
      of = 3'($urandom_range(7));
      if ($urandom_range(5) != 0) of[0] = 1'b0;
      tg = tags[$urandom_range(3)];
      if (!en) r = "R2";
      else if (of[0]) r = "R3";
      else if (cm && wr) r = (tk[li] && mt[li] == tg) ? "R5" : "R6";
      else if (wr) r = "R7";
      else if (cm) r = "R4";
      else r = "R8";
      op(en, cm, wr, li, of, tg, 16'($urandom), vi, r);
    end
    // R9 reset clears flags, keeps tags
    op(1, 1, 1, 8'd5, 3'd0, mt[5], 16'h3333, 0, "R5");
    do_reset();
    op(1, 0, 0, 8'd5, 3'd0, 5'h0, 16'h0, 0, "R9");
    op(1, 1, 0, 8'd255, 3'd0, mt[255], 16'h0, 0, "R9");
    @(negedge clk);
    #10;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule